// File: doc/BRIEF.md
# Hardware Mutex Register File

This block is a shared table of mutual-exclusion locks used by several task contexts of a multi-context processor. Every entry carries a lock bit and the identifier of the context that owns it. A context sends one of three commands, with a mutex index and its own context number. The commands are a blocking lock, a non-blocking accept, and a release. The block decides the outcome in a single indivisible step and reports it on a status code one cycle later.

When a held mutex is released, the block scans every context's wait vector in parallel for the released index. It picks the eligible waiter with the best priority. Ownership goes straight to that waiter, so the lock never becomes free in between. A one-cycle wake pulse is raised on that context's bit of the wake vector. The scheduler tells the block that a context switch is under way by raising the inhibit input. While inhibit is high, commands are not executed; the requester keeps its command asserted until inhibit drops. A per-mutex enable mask selects which entries are in use. A read port shows any entry's contents.

Top module: `mtx_file`

## Requirements
- R1: After a synchronous reset every entry is free with owner 0, the status is NONE (0) and the wake vector is all zeros.
- R2: A lock (command 1) or accept (command 3) on a free, enabled mutex from a context that owns nothing returns GRANT (1), sets the lock bit and records the requester as owner.
- R3: A lock on a mutex that is already owned returns PEND (3); an accept on an owned mutex returns BUSY (2). Neither changes any entry.
- R4: A lock or accept from a context that already owns a mutex returns BUSY (2) and changes nothing. This check takes precedence over R3, so no context ever owns more than one mutex.
- R5: A release (command 2) of a free mutex, or from a context other than the owner, returns ERR (4) and changes nothing.
- R6: A valid release with no eligible waiter returns GRANT, clears the lock bit and resets the owner to 0, with no wake pulse.
- R7: A valid release with eligible waiters returns GRANT. The waiter with the lowest priority value wins, and ties go to the lowest context number. It becomes the owner while the lock bit stays set. Its wake bit is set for exactly the one cycle after the release.
- R8: A context waiting on the released index is not eligible if it already owns a mutex; this includes the releaser.
- R9: While inhibit is high, a command has no effect and the status reads NONE. The command executes in the first cycle in which inhibit is low.
- R10: Any command on a mutex whose mask bit is 0 returns ERR and changes nothing. Mask changes never raise a wake bit.
- R11: The read port combinationally returns the lock bit and owner of the entry selected by the read index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | 0 none, 1 lock, 2 release, 3 accept |
| idx_i | input | MW | Mutex index of the command |
| req_i | input | CW | Requesting context |
| inhibit_i | input | 1 | Context switch in progress; commands are held back |
| mask_i | input | NMUX | Per-mutex enable |
| wait_i | input | NCTX*NMUX | Wait vectors; bit c*NMUX+m means context c waits on mutex m |
| prio_i | input | NCTX*PRIW | Context priorities, field c at c*PRIW; a lower value is more urgent |
| status_o | output | 3 | Result of the last executed command (codes in R1 to R5) |
| wake_o | output | NCTX | One-cycle mutex event per context |
| rd_idx_i | input | MW | Read-port index |
| rd_lock_o | output | 1 | Lock bit of the selected entry |
| rd_owner_o | output | CW | Owner of the selected entry |

## Verification
The hardest case to reach from the ports is a release that hands over ownership while waiters of different kinds are mixed together. Some waiters are eligible, some are barred because they already hold another mutex, and some have equal priorities. Reaching it needs a valid owner release with several mutexes held at once. The random sweep therefore sends most releases with the current owner as requester, and draws fresh wait vectors and priorities for every command. A directed sequence before the sweep sets up one barred waiter, one eligible waiter with a worse priority, and one eligible waiter with a better priority.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_LOCK    = 2'd1,
        CMD_RELEASE = 2'd2,
        CMD_ACCEPT  = 2'd3
    } mtx_cmd_e;

    typedef enum logic [2:0] {
        ST_NONE  = 3'd0,
        ST_GRANT = 3'd1,
        ST_BUSY  = 3'd2,
        ST_PEND  = 3'd3,
        ST_ERR   = 3'd4
    } mtx_status_e;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_TAKE    = 2'd1,
        ACT_FREE    = 2'd2,
        ACT_HANDOFF = 2'd3
    } mtx_action_e;

    typedef struct packed {
        mtx_status_e status;
        mtx_action_e act;
    } mtx_decision_t;

    // Outcome of one command given the selected entry and requester state.
    function automatic mtx_decision_t mtx_decide(
        input mtx_cmd_e cmd,
        input logic     enabled,
        input logic     locked,
        input logic     mine,
        input logic     req_holds,
        input logic     have_waiter
    );
        mtx_decision_t d;
        d.status = ST_NONE;
        d.act    = ACT_NONE;
        if (cmd != CMD_NONE) begin
            if (!enabled) begin
                d.status = ST_ERR;
            end else if (cmd == CMD_RELEASE) begin
                if (!locked || !mine) begin
                    d.status = ST_ERR;
                end else begin
                    d.status = ST_GRANT;
                    d.act    = have_waiter ? ACT_HANDOFF : ACT_FREE;
                end
            end else begin
                if (req_holds) begin
                    d.status = ST_BUSY;
                end else if (locked) begin
                    d.status = (cmd == CMD_LOCK) ? ST_PEND : ST_BUSY;
                end else begin
                    d.status = ST_GRANT;
                    d.act    = ACT_TAKE;
                end
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/mtx_holds.sv
module mtx_holds #(
    parameter int NCTX = 4,
    parameter int NMUX = 4,
    parameter int CW   = 2
) (
    input  logic [NMUX-1:0]    lock_i,
    input  logic [NMUX*CW-1:0] owner_i,
    output logic [NCTX-1:0]    held_o
);
    // Flag every context that appears as owner of a locked entry.
    always_comb begin
        held_o = '0;
        for (int m = 0; m < NMUX; m++) begin
            if (lock_i[m]) begin
                held_o[owner_i[m*CW +: CW]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mtx_arbiter.sv
module mtx_arbiter #(
    parameter int NCTX = 4,
    parameter int PRIW = 2,
    parameter int CW   = 2
) (
    input  logic [NCTX-1:0]      cand_i,
    input  logic [NCTX*PRIW-1:0] prio_i,
    output logic                 any_o,
    output logic [CW-1:0]        sel_o,
    output logic [NCTX-1:0]      grant_o
);
    logic [PRIW-1:0] best;

    // Lowest priority value wins; strict compare keeps ties at lower index.
    always_comb begin
        any_o = 1'b0;
        sel_o = '0;
        best  = '0;
        for (int c = 0; c < NCTX; c++) begin
            if (cand_i[c] && (!any_o || prio_i[c*PRIW +: PRIW] < best)) begin
                any_o = 1'b1;
                sel_o = CW'(c);
                best  = prio_i[c*PRIW +: PRIW];
            end
        end
    end

    always_comb begin
        grant_o = '0;
        if (any_o) begin
            grant_o[sel_o] = 1'b1;
        end
    end
endmodule

// File: rtl/mtx_file.sv
module mtx_file
    import mtx_pkg::*;
#(
    parameter int NCTX = 4,
    parameter int NMUX = 4,
    parameter int PRIW = 2,
    localparam int CW  = (NCTX > 1) ? $clog2(NCTX) : 1,
    localparam int MW  = (NMUX > 1) ? $clog2(NMUX) : 1
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [1:0]           cmd_i,
    input  logic [MW-1:0]        idx_i,
    input  logic [CW-1:0]        req_i,
    input  logic                 inhibit_i,
    input  logic [NMUX-1:0]      mask_i,
    input  logic [NCTX*NMUX-1:0] wait_i,
    input  logic [NCTX*PRIW-1:0] prio_i,
    output logic [2:0]           status_o,
    output logic [NCTX-1:0]      wake_o,
    input  logic [MW-1:0]        rd_idx_i,
    output logic                 rd_lock_o,
    output logic [CW-1:0]        rd_owner_o
);
    logic [NMUX-1:0]    lock_q;
    logic [NMUX*CW-1:0] owner_q;
    mtx_status_e        status_q;
    logic [NCTX-1:0]    wake_q;

    logic [NCTX-1:0]    held;
    logic [NCTX-1:0]    wait_col;
    logic [NCTX-1:0]    cand;
    logic               any_waiter;
    logic [CW-1:0]      win_sel;
    logic [NCTX-1:0]    win_vec;
    logic [CW-1:0]      cur_owner;
    mtx_decision_t      dec;

    mtx_holds #(.NCTX(NCTX), .NMUX(NMUX), .CW(CW)) u_holds (
        .lock_i  (lock_q),
        .owner_i (owner_q),
        .held_o  (held)
    );

    // Associative search: column of every context's wait vector at idx_i.
    for (genvar g = 0; g < NCTX; g++) begin : g_col
        assign wait_col[g] = wait_i[g*NMUX + int'(idx_i)];
    end

    assign cand = wait_col & ~held;

    mtx_arbiter #(.NCTX(NCTX), .PRIW(PRIW), .CW(CW)) u_arb (
        .cand_i  (cand),
        .prio_i  (prio_i),
        .any_o   (any_waiter),
        .sel_o   (win_sel),
        .grant_o (win_vec)
    );

    assign cur_owner = owner_q[idx_i*CW +: CW];

    always_comb begin
        dec = mtx_decide(inhibit_i ? CMD_NONE : mtx_cmd_e'(cmd_i),
                         mask_i[idx_i], lock_q[idx_i],
                         cur_owner == req_i, held[req_i], any_waiter);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lock_q   <= '0;
            owner_q  <= '0;
            status_q <= ST_NONE;
            wake_q   <= '0;
        end else begin
            status_q <= dec.status;
            wake_q   <= '0;
            case (dec.act)
                ACT_TAKE: begin
                    lock_q[idx_i]              <= 1'b1;
                    owner_q[idx_i*CW +: CW]    <= req_i;
                end
                ACT_FREE: begin
                    lock_q[idx_i]              <= 1'b0;
                    owner_q[idx_i*CW +: CW]    <= '0;
                end
                ACT_HANDOFF: begin
                    owner_q[idx_i*CW +: CW]    <= win_sel;
                    wake_q                     <= win_vec;
                end
                default: ;
            endcase
        end
    end

    assign status_o   = status_q;
    assign wake_o     = wake_q;
    assign rd_lock_o  = lock_q[rd_idx_i];
    assign rd_owner_o = owner_q[rd_idx_i*CW +: CW];

endmodule

// File: rtl/mtx_file_chk.sv
module mtx_file_chk
    import mtx_pkg::*;
#(
    parameter int NCTX = 4,
    parameter int NMUX = 4,
    parameter int CW   = 2,
    parameter int MW   = 2
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic [1:0]         cmd_i,
    input logic [MW-1:0]      idx_i,
    input logic               inhibit_i,
    input logic [2:0]         status_o,
    input logic [NCTX-1:0]    wake_o,
    input logic [NMUX-1:0]    lock_q,
    input logic [NMUX*CW-1:0] owner_q
);
    function automatic int owned_by(input int c);
        int n = 0;
        for (int m = 0; m < NMUX; m++) begin
            if (lock_q[m] && int'(owner_q[m*CW +: CW]) == c) n++;
        end
        return n;
    endfunction

    assert_wake_onehot_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(wake_o));

    assert_wake_cause_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (|wake_o) |-> ($past(cmd_i) == 2'(CMD_RELEASE) && !$past(inhibit_i)));

    assert_handoff_locked_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (|wake_o) |-> lock_q[$past(idx_i)]);

    assert_inhibit_quiet_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        inhibit_i |=> (status_o == 3'(ST_NONE) && $stable(lock_q) && $stable(owner_q)));

    assert_err_no_change_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_o == 3'(ST_ERR)) |-> ($stable(lock_q) && $stable(owner_q)));

    assert_refuse_no_change_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_o == 3'(ST_PEND) || status_o == 3'(ST_BUSY)) |-> ($stable(lock_q) && $stable(owner_q)));

    always @(posedge clk_i) begin
        if (!rst_i) begin
            for (int c = 0; c < NCTX; c++) begin
                assert_single_hold_R4: assert (owned_by(c) <= 1);
            end
        end
    end
endmodule

bind mtx_file mtx_file_chk #(.NCTX(NCTX), .NMUX(NMUX), .CW(CW), .MW(MW)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .cmd_i     (cmd_i),
    .idx_i     (idx_i),
    .inhibit_i (inhibit_i),
    .status_o  (status_o),
    .wake_o    (wake_o),
    .lock_q    (lock_q),
    .owner_q   (owner_q)
);

// File: tb/test_mtx_file.sv
module test_mtx_file;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cmd;
    logic [1:0]  idx;
    logic [1:0]  req;
    logic        inh;
    logic [3:0]  mask;
    logic [15:0] waitv;
    logic [7:0]  prio;
    logic [2:0]  status;
    logic [3:0]  wake;
    logic [1:0]  rd_idx;
    logic        rd_lock;
    logic [1:0]  rd_owner;

    int compared = 0;
    int mismatched = 0;
    int m_lk[4];
    int m_ow[4];
    bit finished = 0;

    always #2 clk = ~clk;

    mtx_file #(.NCTX(4), .NMUX(4), .PRIW(2)) i_mtx_file (
        .clk_i(clk), .rst_i(rst), .cmd_i(cmd), .idx_i(idx), .req_i(req),
        .inhibit_i(inh), .mask_i(mask), .wait_i(waitv), .prio_i(prio),
        .status_o(status), .wake_o(wake), .rd_idx_i(rd_idx),
        .rd_lock_o(rd_lock), .rd_owner_o(rd_owner)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input int c, input int ix, input int rq, input bit ih,
                          input logic [3:0] mk, input logic [15:0] wv, input logic [7:0] pr);
        int held[4];
        int est;
        logic [3:0] ewake;
        string tag;
        int best;
        bit barred;
        held = '{0, 0, 0, 0};
        for (int m = 0; m < 4; m++) if (m_lk[m] != 0) held[m_ow[m]] = 1;
        est = 0; ewake = '0; tag = "R9"; barred = 0;
        if (c == 0 || ih) begin
            est = 0; tag = "R9";
        end else if (!mk[ix]) begin
            est = 4; tag = "R10";
        end else if (c == 1 || c == 3) begin
            if (held[rq] != 0) begin
                est = 2; tag = "R4";
            end else if (m_lk[ix] != 0) begin
                est = (c == 1) ? 3 : 2; tag = "R3";
            end else begin
                est = 1; tag = "R2"; m_lk[ix] = 1; m_ow[ix] = rq;
            end
        end else begin
            if (m_lk[ix] == 0 || m_ow[ix] != rq) begin
                est = 4; tag = "R5";
            end else begin
                best = -1;
                for (int k = 0; k < 4; k++) begin
                    if (wv[k*4 + ix]) begin
                        if (held[k] != 0) barred = 1;
                        else if (best < 0 || pr[k*2 +: 2] < pr[best*2 +: 2]) best = k;
                    end
                end
                est = 1;
                if (best < 0) begin
                    tag = barred ? "R8" : "R6"; m_lk[ix] = 0; m_ow[ix] = 0;
                end else begin
                    tag = barred ? "R8" : "R7"; ewake[best] = 1'b1; m_ow[ix] = best;
                end
            end
        end
        cmd = 2'(c); idx = 2'(ix); req = 2'(rq); inh = ih; mask = mk;
        waitv = wv; prio = pr; rd_idx = 2'(ix);
        @(posedge clk);
        @(negedge clk);
        check(status == 3'(est), tag, "status", int'(status), est);
        check(wake == ewake, tag, "wake", int'(wake), int'(ewake));
        check(rd_lock == m_lk[ix][0] && int'(rd_owner) == m_ow[ix], "R11",
              "read lock*4+owner", int'(rd_lock)*4 + int'(rd_owner), m_lk[ix]*4 + m_ow[ix]);
        cmd = 2'd0; inh = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #800000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; cmd = '0; idx = '0; req = '0; inh = 1'b0; mask = 4'hF;
        waitv = '0; prio = '0; rd_idx = '0;
        for (int m = 0; m < 4; m++) begin m_lk[m] = 0; m_ow[m] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state on every entry and on the outputs
        check(status == 3'd0, "R1", "status", int'(status), 0);
        check(wake == 4'd0, "R1", "wake", int'(wake), 0);
        for (int m = 0; m < 4; m++) begin
            rd_idx = 2'(m);
            #1;
            check(rd_lock == 1'b0 && rd_owner == 2'd0, "R1", "entry",
                  int'(rd_lock)*4 + int'(rd_owner), 0);
        end

        // Directed handoff: ctx1 barred (holds m1), ctx3 beats ctx2 on priority
        run_op(1, 0, 0, 0, 4'hF, 16'h0, 8'h0);          // R2 ctx0 takes m0
        run_op(1, 1, 1, 0, 4'hF, 16'h0, 8'h0);          // R2 ctx1 takes m1
        run_op(1, 0, 2, 0, 4'hF, 16'h0, 8'h0);          // R3 pend
        run_op(3, 0, 3, 0, 4'hF, 16'h0, 8'h0);          // R3 busy
        run_op(1, 2, 1, 0, 4'hF, 16'h0, 8'h0);          // R4
        run_op(2, 0, 2, 0, 4'hF, 16'h0, 8'h0);          // R5 not owner
        run_op(2, 0, 0, 1, 4'hF, 16'h1110, 8'b01_10_00_00); // R9 held back
        run_op(2, 0, 0, 0, 4'hE, 16'h1110, 8'b01_10_00_00); // R10 disabled
        run_op(0, 0, 0, 0, 4'h0, 16'hFFFF, 8'h0);       // R10 mask change, no wake
        run_op(2, 0, 0, 0, 4'hF, 16'h1110, 8'b01_10_00_00); // R8/R7 -> ctx3
        run_op(2, 0, 3, 0, 4'hF, 16'h0, 8'h0);          // R6 free
        run_op(2, 3, 0, 0, 4'hF, 16'h0, 8'h0);          // R5 free mutex

        // Random sweep biased toward valid owner releases
        for (int n = 0; n < 4000; n++) begin
            int c; int ix; int rq; bit ih; logic [3:0] mk;
            c  = int'($urandom_range(1, 3));
            ix = int'($urandom_range(0, 3));
            rq = int'($urandom_range(0, 3));
            if (c == 2 && m_lk[ix] != 0 && $urandom_range(0, 3) != 0) rq = m_ow[ix];
            ih = ($urandom_range(0, 7) == 0);
            mk = ($urandom_range(0, 15) == 0) ? 4'($urandom_range(0, 15)) : 4'hF;
            run_op(c, ix, rq, ih, mk, 16'($urandom), 8'($urandom));
        end

        // R11: final read of every entry
        for (int m = 0; m < 4; m++) begin
            rd_idx = 2'(m);
            #1;
            check(rd_lock == m_lk[m][0] && int'(rd_owner) == m_ow[m], "R11", "final entry",
                  int'(rd_lock)*4 + int'(rd_owner), m_lk[m]*4 + m_ow[m]);
        end
        summary();
    end
endmodule